// File: doc/BRIEF.md
# Flagged Register Bank for a Three-Phase Serial Datapath

This block is the working storage of a small 16-bit serial processor core. It holds four 16-bit general registers and two status bits, carry and zero. One write port stores a result into the register named by a 2-bit destination number. Two combinational read ports present the registers named by the destination number and by the source number in the same cycle. These ports feed the ALU operands and the memory address and data paths.

Every state change happens on the falling edge of a commit strobe. The processor's phase generator drives that strobe with its last phase of each instruction. Three independent enables decide which of the destination register, the carry bit and the zero bit take new values on a given strobe edge. All register contents and both flags are also driven out for debug observation. An asynchronous active-low reset clears everything.

Top module: `rf_status_regfile`

## Requirements
- R1: The bank holds four 16-bit registers numbered 0 to 3. Register k appears on `regs_o[16k+15:16k]`.
- R2: `dst_rdata_o` shows, combinationally, the register whose number is on `dst_sel_i`.
- R3: `src_rdata_o` shows, combinationally, the register whose number is on `src_sel_i`. It is independent of the destination read port, and both are valid in the same cycle, including when both numbers are equal.
- R4: On a falling edge of `strobe_i` with `dst_we_i` = 1, the register named by `dst_sel_i` takes `wdata_i`. The other three registers keep their values.
- R5: On a falling edge of `strobe_i` with `dst_we_i` = 0, no register changes.
- R6: On a falling edge of `strobe_i`, `carry_o` takes `carry_i` if `carry_upd_i` = 1 and otherwise keeps its value.
- R7: On a falling edge of `strobe_i`, `zero_o` takes `zero_i` if `zero_upd_i` = 1 and otherwise keeps its value.
- R8: While `rst_ni` = 0, all registers and both flags are 0, whatever the strobe and enables do. This holds even for a strobe edge that falls during reset.
- R9: The three enables act independently, and any combination of them may be active on one strobe edge.
- R10: There is no write-through bypass. Until the falling strobe edge, both read ports show the old value of the register being written. A rising strobe edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe_i | input | 1 | Commit strobe (last CPU phase); state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dst_sel_i | input | 2 | Destination register number (write and first read port) |
| src_sel_i | input | 2 | Source register number (second read port) |
| dst_we_i | input | 1 | Destination register write enable |
| wdata_i | input | 16 | Data written into the destination register |
| carry_upd_i | input | 1 | Carry flag update enable |
| carry_i | input | 1 | Carry produced by the current instruction |
| zero_upd_i | input | 1 | Zero flag update enable |
| zero_i | input | 1 | Zero result of the current instruction |
| dst_rdata_o | output | 16 | Contents of the destination register |
| src_rdata_o | output | 16 | Contents of the source register |
| regs_o | output | 64 | All four registers, register k at bits 16k+15:16k |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
The hardest case to reach from the ports is a strobe that is already high, with a write enabled, when reset arrives and stays low across the falling edge. The bench raises the strobe with a write pending, pulls reset low, drops the strobe, and only then releases reset. It then expects all zeros. A second awkward case is a read of the register being written while the strobe is high. The bench samples both read ports mid-pulse and expects the old value there, then the new one after the fall. Table vectors and a pseudo-random phase mix enable combinations and equal destination and source numbers.

// File: rtl/rf_status_pkg.sv
package rf_status_pkg;
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_NUM_REGS = 4;

  typedef struct packed {
    logic carry;
    logic zero;
  } flags_t;
endpackage

// File: rtl/rf_data_bank.sv
module rf_data_bank #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       strobe_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(k));

    always_ff @(negedge strobe_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[k] <= '0;
      else if (hit) mem_q[k] <= wdata_i;
    end

    assign regs_o[k*DATA_W +: DATA_W] = mem_q[k];

    // unselected registers keep their value
    a_r5_untouched_stable: assert property (@(negedge strobe_i) disable iff (!rst_ni)
      !(we_i && sel_i == SEL_W'(k)) |=> $stable(regs_o[k*DATA_W +: DATA_W]));
  end

  a_r4_write_commits: assert property (@(negedge strobe_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(sel_i)] == $past(wdata_i)));
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [DATA_W-1:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (sel_i == SEL_W'(k)) rdata_o = regs_i[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/rf_flag_bit.sv
module rf_flag_bit (
  input  logic strobe_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic val_i,
  output logic flag_o
);
  always_ff @(negedge strobe_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (upd_i) flag_o <= val_i;
  end

  a_r6_flag_loads: assert property (@(negedge strobe_i) disable iff (!rst_ni)
    upd_i |=> (flag_o == $past(val_i)));
  a_r7_flag_holds: assert property (@(negedge strobe_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flag_o));
endmodule

// File: rtl/rf_status_regfile.sv
module rf_status_regfile
  import rf_status_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       strobe_i,
  input  logic                       rst_ni,
  input  logic [SEL_W-1:0]           dst_sel_i,
  input  logic [SEL_W-1:0]           src_sel_i,
  input  logic                       dst_we_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       carry_upd_i,
  input  logic                       carry_i,
  input  logic                       zero_upd_i,
  input  logic                       zero_i,
  output logic [DATA_W-1:0]          dst_rdata_o,
  output logic [DATA_W-1:0]          src_rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       carry_o,
  output logic                       zero_o
);
  flags_t flags;

  rf_data_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .strobe_i (strobe_i),
    .rst_ni   (rst_ni),
    .we_i     (dst_we_i),
    .sel_i    (dst_sel_i),
    .wdata_i  (wdata_i),
    .regs_o   (regs_o)
  );

  rf_read_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dst_rd (
    .regs_i (regs_o), .sel_i (dst_sel_i), .rdata_o (dst_rdata_o)
  );

  rf_read_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_src_rd (
    .regs_i (regs_o), .sel_i (src_sel_i), .rdata_o (src_rdata_o)
  );

  rf_flag_bit u_carry (
    .strobe_i (strobe_i), .rst_ni (rst_ni),
    .upd_i (carry_upd_i), .val_i (carry_i), .flag_o (flags.carry)
  );

  rf_flag_bit u_zero (
    .strobe_i (strobe_i), .rst_ni (rst_ni),
    .upd_i (zero_upd_i), .val_i (zero_i), .flag_o (flags.zero)
  );

  assign carry_o = flags.carry;
  assign zero_o  = flags.zero;

  // R9: a register write does not disturb a flag whose enable is off
  a_r9_write_keeps_carry: assert property (@(negedge strobe_i) disable iff (!rst_ni)
    (dst_we_i && !carry_upd_i) |=> $stable(carry_o));
endmodule

// File: tb/sim_rf_status_regfile.sv
module sim_rf_status_regfile;
  localparam int W = 16;
  localparam int N = 4;
  localparam int NV = 12;

  // {dst, src, we, carry_upd, zero_upd, carry, zero, wdata}
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'hA5A5},
    {2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1234},
    {2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF},
    {2'd3, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0001},
    {2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'hDEAD},
    {2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h8000},
    {2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0BAD},
    {2'd3, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000},
    {2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h7FFF},
    {2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h5555},
    {2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF},
    {2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hC3C3}
  };

  logic clk = 1'b0;
  logic strobe = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] dst_sel = '0, src_sel = '0;
  logic dst_we = 1'b0, carry_upd = 1'b0, carry_in = 1'b0, zero_upd = 1'b0, zero_in = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] dst_rdata, src_rdata;
  logic [N*W-1:0] regs;
  logic carry, zero;

  logic [W-1:0] m_reg [N];
  logic m_c, m_z;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rf_status_regfile u0 (
    .strobe_i (strobe), .rst_ni (rst_n),
    .dst_sel_i (dst_sel), .src_sel_i (src_sel), .dst_we_i (dst_we), .wdata_i (wdata),
    .carry_upd_i (carry_upd), .carry_i (carry_in), .zero_upd_i (zero_upd), .zero_i (zero_in),
    .dst_rdata_o (dst_rdata), .src_rdata_o (src_rdata), .regs_o (regs),
    .carry_o (carry), .zero_o (zero)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    for (int k = 0; k < N; k++)
      chk($sformatf("R1/R4/R5 %s reg%0d", ctx, k), regs[k*W +: W], m_reg[k]);
    chk({"R2 ", ctx, " dst port"}, dst_rdata, m_reg[dst_sel]);
    chk({"R3 ", ctx, " src port"}, src_rdata, m_reg[src_sel]);
    chk({"R6 ", ctx, " carry"}, {15'd0, carry}, {15'd0, m_c});
    chk({"R7 ", ctx, " zero"}, {15'd0, zero}, {15'd0, m_z});
  endtask

  task automatic apply(input logic [24:0] v);
    {dst_sel, src_sel, dst_we, carry_upd, zero_upd, carry_in, zero_in, wdata} = v;
  endtask

  // strobe pulse; model commits at the falling edge (R4..R7, R9)
  task automatic pulse();
    @(posedge clk); #2 strobe = 1'b1;
    @(posedge clk); #2 strobe = 1'b0;
    if (dst_we)    m_reg[dst_sel] = wdata;
    if (carry_upd) m_c = carry_in;
    if (zero_upd)  m_z = zero_in;
    #3;
  endtask

  initial begin
    m_c = 1'b0; m_z = 1'b0;
    for (int k = 0; k < N; k++) m_reg[k] = '0;
    repeat (3) @(posedge clk);
    #5;
    check_all("R8 reset state");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      pulse();
      check_all($sformatf("R9 vec%0d", i));
    end

    // R10: read of the register being written shows old value while strobe is high
    apply({2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h6A6A});
    @(posedge clk); #2 strobe = 1'b1;
    #5;
    chk("R10 dst port before fall", dst_rdata, m_reg[2]);
    chk("R10 src port before fall", src_rdata, m_reg[2]);
    chk("R10 reg2 after rising edge", regs[2*W +: W], m_reg[2]);
    @(posedge clk); #2 strobe = 1'b0;
    m_reg[2] = 16'h6A6A;
    #3;
    check_all("R10 after fall");

    // pseudo-random mix of selects, data and enables
    for (int i = 0; i < 40; i++) begin
      apply(25'($urandom));
      pulse();
      check_all($sformatf("R9 rnd%0d", i));
    end

    // R8: reset arrives with strobe high and a full write pending, strobe falls under reset
    apply({2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hBEEF});
    @(posedge clk); #2 strobe = 1'b1;
    #3 rst_n = 1'b0;
    @(posedge clk); #2 strobe = 1'b0;
    for (int k = 0; k < N; k++) m_reg[k] = '0;
    m_c = 1'b0; m_z = 1'b0;
    #3;
    check_all("R8 reset over write");
    rst_n = 1'b1;
    #3;
    check_all("R8 after release");

    // R5: write enable off changes nothing, flags touched
    apply({2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFACE});
    pulse();
    check_all("R5 no write");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule